// File: doc/BRIEF.md
# ADC Sample Ingress Normaliser

This block is the first processing stage behind one 17-bit parallel converter bus. Each incoming word is read either as a plain fixed-point sample or as a floating-point pair. In the floating-point case the low bits carry an exponent and the upper bits carry a mantissa. The exponent found on the bus can be added to a gain exponent supplied by a separate range-control block. The mantissa is then shifted left by the summed exponent into a signed 24-bit word, and the result saturates instead of wrapping. The incoming code may be two's complement or offset binary.

An active-low enable sets the sampling rhythm, and a mode setting chooses how it is used. In gated mode only enabled words produce output. In zero-stuffing mode the block produces output on every clock and replaces disabled words with zero. In slot-pick mode the block takes one word out of a time-multiplexed frame of up to eight words. The output is a normalised word and a valid strobe that travels with it.

Top module: `adc_front_ingress`

## Requirements
- R1: While reset is high, and in the cycle after it, `out_valid` is 0 and `out_sample` is 0.
- R2: With `cfg_format`=0 (fixed point), the entire 17-bit word is the mantissa, the bus supplies no exponent, and `out_sample` equals the sign-extended word shifted left by `cfg_range_exp`.
- R3: When `cfg_offset_bin`=1, bit 16 of the mantissa field is inverted before sign extension. This applies in every format. When it is 0, the word is read as two's complement.
- R4: A `cfg_format` of 1, 2 or 3 places a 3-, 2- or 1-bit exponent in the lowest bits of the bus and the mantissa in bits 16 down to 3, 2 or 1. The output is the signed mantissa shifted left by the bus exponent plus `cfg_range_exp`.
- R5: When `cfg_pin_exp_en`=0, the exponent bits on the bus are ignored, and only `cfg_range_exp` sets the shift.
- R6: A shifted value above 8388607 is output as 24'h7FFFFF. A shifted value below -8388608 is output as 24'h800000.
- R7: In gated mode (`cfg_en_mode`=0), a word sampled with `in_en_n` low appears on `out_sample` two clock edges later, with `out_valid`=1. A word sampled with `in_en_n` high produces `out_valid`=0 two edges later, and `out_sample` keeps its previous value.
- R8: In zero-stuffing mode (`cfg_en_mode`=1), `out_valid` is 1 on every cycle with the same two-edge latency. A word sampled with `in_en_n` high is output as 0, whatever its coding.
- R9: In slot-pick mode (`cfg_en_mode`=2), `in_en_n` is low for one clock on slot 0 of each frame. The word arriving `cfg_slot` clocks after that enable is held. At the next frame's enable it moves to the realign stage, and it appears with `out_valid`=1 one edge after that. `out_valid` is 0 on all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_format | input | 2 | 0 fixed, 1 mantissa 14/exp 3, 2 mantissa 15/exp 2, 3 mantissa 16/exp 1 |
| cfg_offset_bin | input | 1 | 1 = offset-binary coding, 0 = two's complement |
| cfg_pin_exp_en | input | 1 | 1 = add the bus exponent to the shift |
| cfg_range_exp | input | 4 | Exponent supplied by external range control |
| cfg_en_mode | input | 2 | 0 gated, 1 zero-stuffing, 2 slot-pick (3 behaves as gated) |
| cfg_slot | input | 3 | Slot index picked in slot-pick mode |
| in_sample | input | 17 | Raw converter word |
| in_en_n | input | 1 | Active-low sample enable |
| out_sample | output | 24 | Normalised signed sample |
| out_valid | output | 1 | Processing-enable strobe aligned with `out_sample` |

## Verification
The assertions are checked on every cycle. They cover the reset state and the stall rule: a disabled word in gated or slot-pick mode gives no valid and leaves the output word unchanged. They also check that in zero-stuffing mode a disabled word gives a valid zero. The numeric side can only be shown by the bench scenarios. This covers format splitting, offset-binary inversion, exponent summing, the bus-exponent disable and both saturation limits. It also covers which slot of a frame is picked and the one-frame realignment delay.

// File: rtl/ingress_pkg.sv
package ingress_pkg;

    localparam int unsigned ING_IN_W     = 17;
    localparam int unsigned ING_OUT_W    = 24;
    localparam int unsigned ING_RC_W     = 4;
    localparam int unsigned ING_PIN_XMAX = 7;
    localparam int unsigned ING_MAX_TOT  = (2 ** ING_RC_W - 1) + ING_PIN_XMAX;
    localparam int unsigned ING_TOT_W    = $clog2(ING_MAX_TOT + 1);
    localparam int unsigned ING_WIDE_W   = ING_IN_W + ING_MAX_TOT + 1;

    localparam logic signed [ING_WIDE_W-1:0] SAT_HI =
        ING_WIDE_W'((longint'(1) <<< (ING_OUT_W - 1)) - 1);
    localparam logic signed [ING_WIDE_W-1:0] SAT_LO = -SAT_HI - 1;

    typedef enum logic [1:0] {
        FMT_FIXED = 2'd0,
        FMT_M14   = 2'd1,
        FMT_M15   = 2'd2,
        FMT_M16   = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        MODE_GATED  = 2'd0,
        MODE_STUFF  = 2'd1,
        MODE_SLOT   = 2'd2,
        MODE_SPARE  = 2'd3
    } mode_e;

    typedef struct packed {
        logic                valid;
        logic                zero;
        logic [ING_IN_W-1:0] raw;
    } stage_t;

    typedef struct packed {
        fmt_e                format;
        logic                offset_bin;
        logic                pin_exp_en;
        logic [ING_RC_W-1:0] range_exp;
    } num_cfg_t;

    // number of exponent bits carried in the low end of the bus
    function automatic logic [1:0] exp_bits(input fmt_e f);
        case (f)
            FMT_M14: return 2'd3;
            FMT_M15: return 2'd2;
            FMT_M16: return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [ING_OUT_W-1:0] normalise(input logic [ING_IN_W-1:0] raw,
                                                        input num_cfg_t       c);
        logic [1:0]                   eb;
        logic [ING_IN_W-1:0]          low_mask;
        logic [ING_IN_W-1:0]          mant_top;
        logic [ING_TOT_W-1:0]         tot;
        logic signed [ING_WIDE_W-1:0] w;
        eb       = exp_bits(c.format);
        low_mask = ING_IN_W'((32'd1 << eb) - 32'd1);
        // mantissa kept in place at the top, exponent bits cleared
        mant_top = raw & ~low_mask;
        mant_top[ING_IN_W-1] = mant_top[ING_IN_W-1] ^ c.offset_bin;
        tot = ING_TOT_W'(c.range_exp);
        if (c.pin_exp_en)
            tot = tot + ING_TOT_W'(raw & low_mask);
        w = {{(ING_WIDE_W - ING_IN_W){mant_top[ING_IN_W-1]}}, mant_top};
        w = w <<< tot;
        w = w >>> eb;
        if (w > SAT_HI)
            w = SAT_HI;
        else if (w < SAT_LO)
            w = SAT_LO;
        return w[ING_OUT_W-1:0];
    endfunction

endpackage

// File: rtl/ingress_tap_delay.sv
module ingress_tap_delay #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned SEL_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [SEL_W-1:0] sel,
    output logic             fire
);
    logic [DEPTH-1:1] dly;
    logic [DEPTH-1:0] taps;

    assign taps = {dly, start};

    for (genvar k = 1; k < DEPTH; k++) begin : g_dly
        always_ff @(posedge clk) begin
            if (rst) dly[k] <= 1'b0;
            else     dly[k] <= taps[k-1];
        end
    end

    assign fire = taps[sel];
endmodule

// File: rtl/ingress_capture.sv
module ingress_capture
    import ingress_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  mode_e               mode,
    input  logic                en_n,
    input  logic [ING_IN_W-1:0] data,
    input  logic                fire,
    output stage_t              stage
);
    logic [ING_IN_W-1:0] pick_q;

    // selection register for slot-pick mode, loaded by the delayed enable
    always_ff @(posedge clk) begin
        if (rst)       pick_q <= '0;
        else if (fire) pick_q <= data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
        end else begin
            unique case (mode)
                MODE_STUFF: begin
                    stage.valid <= 1'b1;
                    stage.zero  <= en_n;
                    stage.raw   <= data;
                end
                MODE_SLOT: begin
                    // realign register driven by the undelayed enable
                    stage.valid <= ~en_n;
                    stage.zero  <= 1'b0;
                    if (!en_n) stage.raw <= pick_q;
                end
                default: begin
                    stage.valid <= ~en_n;
                    stage.zero  <= 1'b0;
                    if (!en_n) stage.raw <= data;
                end
            endcase
        end
    end
endmodule

// File: rtl/ingress_normalize.sv
module ingress_normalize
    import ingress_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  stage_t               stage,
    input  num_cfg_t             cfg,
    output logic [ING_OUT_W-1:0] out_sample,
    output logic                 out_valid
);
    logic [ING_OUT_W-1:0] conv;

    always_comb conv = stage.zero ? '0 : normalise(stage.raw, cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= stage.valid;
            if (stage.valid) out_sample <= conv;
        end
    end
endmodule

// File: rtl/adc_front_ingress.sv
module adc_front_ingress
    import ingress_pkg::*;
#(
    parameter int unsigned SLOTS = 8,
    localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           cfg_format,
    input  logic                 cfg_offset_bin,
    input  logic                 cfg_pin_exp_en,
    input  logic [ING_RC_W-1:0]  cfg_range_exp,
    input  logic [1:0]           cfg_en_mode,
    input  logic [SLOT_W-1:0]    cfg_slot,
    input  logic [ING_IN_W-1:0]  in_sample,
    input  logic                 in_en_n,
    output logic [ING_OUT_W-1:0] out_sample,
    output logic                 out_valid
);
    mode_e    mode;
    num_cfg_t ncfg;
    logic     fire;
    stage_t   stage;

    assign mode            = mode_e'(cfg_en_mode);
    assign ncfg.format     = fmt_e'(cfg_format);
    assign ncfg.offset_bin = cfg_offset_bin;
    assign ncfg.pin_exp_en = cfg_pin_exp_en;
    assign ncfg.range_exp  = cfg_range_exp;

    ingress_tap_delay #(.DEPTH(SLOTS)) u_taps (
        .clk   (clk),
        .rst   (rst),
        .start (~in_en_n),
        .sel   (cfg_slot),
        .fire  (fire)
    );

    ingress_capture u_cap (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .en_n  (in_en_n),
        .data  (in_sample),
        .fire  (fire),
        .stage (stage)
    );

    ingress_normalize u_norm (
        .clk        (clk),
        .rst        (rst),
        .stage      (stage),
        .cfg        (ncfg),
        .out_sample (out_sample),
        .out_valid  (out_valid)
    );

    logic gated_m, stuff_m, slot_m;
    assign gated_m = (mode == MODE_GATED) || (mode == MODE_SPARE);
    assign stuff_m = (mode == MODE_STUFF);
    assign slot_m  = (mode == MODE_SLOT);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sample == '0));

    assert_gated_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (gated_m && in_en_n) ##1 gated_m |=> (!out_valid && $stable(out_sample)));

    assert_zero_stuff_R8: assert property (@(posedge clk) disable iff (rst)
        (stuff_m && in_en_n) ##1 stuff_m |=> (out_valid && out_sample == '0));

    assert_slot_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (slot_m && in_en_n) ##1 slot_m |=> (!out_valid && $stable(out_sample)));
endmodule

// File: tb/adc_front_ingress_tb.sv
module adc_front_ingress_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_format = 2'd0;
    logic        cfg_offset_bin = 1'b0;
    logic        cfg_pin_exp_en = 1'b1;
    logic [3:0]  cfg_range_exp = 4'd0;
    logic [1:0]  cfg_en_mode = 2'd0;
    logic [2:0]  cfg_slot = 3'd0;
    logic [16:0] in_sample = '0;
    logic        in_en_n = 1'b1;
    logic [23:0] out_sample;
    logic        out_valid;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    adc_front_ingress dut_i (
        .clk            (clk),
        .rst            (rst),
        .cfg_format     (cfg_format),
        .cfg_offset_bin (cfg_offset_bin),
        .cfg_pin_exp_en (cfg_pin_exp_en),
        .cfg_range_exp  (cfg_range_exp),
        .cfg_en_mode    (cfg_en_mode),
        .cfg_slot       (cfg_slot),
        .in_sample      (in_sample),
        .in_en_n        (in_en_n),
        .out_sample     (out_sample),
        .out_valid      (out_valid)
    );

    task automatic check(input bit cond, input string tag, input logic [23:0] act,
                         input logic [23:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // mode: 0 no check, 1 check valid only, 2 check valid and data
    task automatic step(input logic [16:0] d, input logic en_n, input int mode,
                        input logic ev, input logic [23:0] ed, input string tag);
        @(negedge clk);
        in_sample = d;
        in_en_n   = en_n;
        @(posedge clk);
        #1;
        if (mode >= 1) check(out_valid == ev, {tag, " valid"}, 24'(out_valid), 24'(ev));
        if (mode == 2) check(out_sample == ed, {tag, " data"}, out_sample, ed);
    endtask

    task automatic setup(input logic [1:0] f, input logic ob, input logic pe,
                         input logic [3:0] rc, input logic [1:0] m, input logic [2:0] s);
        @(negedge clk);
        cfg_format = f; cfg_offset_bin = ob; cfg_pin_exp_en = pe;
        cfg_range_exp = rc; cfg_en_mode = m; cfg_slot = s;
        for (int i = 0; i < 9; i++) step(17'h0, 1'b1, 0, 1'b0, 24'h0, "");
    endtask

    task automatic conv(input logic [16:0] d, input logic [23:0] exp, input string tag);
        step(d, 1'b0, 0, 1'b0, 24'h0, tag);
        step(17'h0, 1'b1, 2, 1'b1, exp, tag);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0 && out_sample == 24'h0, "R1 reset idle", out_sample, 24'h0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_fixed;
        setup(2'd0, 1'b0, 1'b1, 4'd0, 2'd0, 3'd0);
        conv(17'h1FFFF, 24'hFFFFFF, "R2 fixed minus one");
        conv(17'h00123, 24'h000123, "R2 fixed positive");
        setup(2'd0, 1'b0, 1'b1, 4'd4, 2'd0, 3'd0);
        conv(17'h00123, 24'h001230, "R2 fixed range shift 4");
    endtask

    task automatic t_offset;
        setup(2'd0, 1'b1, 1'b1, 4'd0, 2'd0, 3'd0);
        conv(17'h10005, 24'h000005, "R3 offset above mid");
        conv(17'h00000, 24'hFF0000, "R3 offset most negative");
        setup(2'd2, 1'b1, 1'b1, 4'd0, 2'd0, 3'd0);
        // 15-bit mantissa 0x0005 offset coded -> top bit set, exp 1
        conv(17'h10015, 24'h00000A, "R3 offset float");
    endtask

    task automatic t_float;
        setup(2'd1, 1'b0, 1'b1, 4'd0, 2'd0, 3'd0);
        conv(17'h00083, 24'h000080, "R4 m14 exp3");
        conv(17'h1FFF2, 24'hFFFFF8, "R4 m14 negative exp2");
        setup(2'd2, 1'b0, 1'b1, 4'd2, 2'd0, 3'd0);
        conv(17'h00017, 24'h0000A0, "R4 m15 exp3 plus range2");
        setup(2'd3, 1'b0, 1'b1, 4'd0, 2'd0, 3'd0);
        conv(17'h00201, 24'h000200, "R4 m16 exp1");
    endtask

    task automatic t_pin_off;
        setup(2'd1, 1'b0, 1'b0, 4'd0, 2'd0, 3'd0);
        conv(17'h00083, 24'h000010, "R5 bus exponent ignored");
        setup(2'd1, 1'b0, 1'b0, 4'd1, 2'd0, 3'd0);
        conv(17'h00087, 24'h000020, "R5 only range exponent");
    endtask

    task automatic t_sat;
        setup(2'd0, 1'b0, 1'b1, 4'd8, 2'd0, 3'd0);
        conv(17'h0FFFF, 24'h7FFFFF, "R6 positive clamp");
        conv(17'h10000, 24'h800000, "R6 negative clamp");
        conv(17'h07FFF, 24'h7FFF00, "R6 edge no clamp");
    endtask

    task automatic t_gated;
        setup(2'd0, 1'b0, 1'b1, 4'd0, 2'd0, 3'd0);
        step(17'h00011, 1'b0, 0, 1'b0, 24'h0, "");
        step(17'h00022, 1'b1, 2, 1'b1, 24'h000011, "R7 gated first");
        step(17'h00033, 1'b0, 2, 1'b0, 24'h000011, "R7 gated stall hold");
        step(17'h00000, 1'b1, 2, 1'b1, 24'h000033, "R7 gated resume");
        step(17'h00000, 1'b1, 2, 1'b0, 24'h000033, "R7 gated idle");
    endtask

    task automatic t_stuff;
        setup(2'd0, 1'b0, 1'b1, 4'd0, 2'd1, 3'd0);
        step(17'h00044, 1'b0, 0, 1'b0, 24'h0, "");
        step(17'h00055, 1'b1, 2, 1'b1, 24'h000044, "R8 stuff sample");
        step(17'h00066, 1'b0, 2, 1'b1, 24'h000000, "R8 stuff zero");
        step(17'h00000, 1'b1, 2, 1'b1, 24'h000066, "R8 stuff next");
        setup(2'd0, 1'b1, 1'b1, 4'd0, 2'd1, 3'd0);
        step(17'h00000, 1'b1, 0, 1'b0, 24'h0, "");
        step(17'h00000, 1'b1, 2, 1'b1, 24'h000000, "R8 stuff zero offset coding");
    endtask

    task automatic t_slot(input logic [2:0] s);
        setup(2'd0, 1'b0, 1'b1, 4'd0, 2'd2, s);
        for (int f = 0; f < 3; f++) begin
            for (int k = 0; k < 8; k++) begin
                logic [16:0] d;
                logic [23:0] e;
                d = 17'(17'h100 + f * 16 + k);
                e = 24'(24'h100 + (f - 1) * 16 + int'(s));
                if (f == 0)
                    step(d, (k != 0), 0, 1'b0, 24'h0, "");
                else if (k == 1)
                    step(d, (k != 0), 2, 1'b1, e, $sformatf("R9 slot %0d frame %0d", s, f));
                else
                    step(d, (k != 0), 1, 1'b0, 24'h0, $sformatf("R9 slot %0d quiet", s));
            end
        end
    endtask

    initial begin
        #(100000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_fixed();
        t_offset();
        t_float();
        t_pin_off();
        t_sat();
        t_gated();
        t_stuff();
        t_slot(3'd0);
        t_slot(3'd3);
        t_slot(3'd7);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule